// File: doc/BRIEF.md
# Automatic Bus Polarity Reversal Controller

This block is the digital control for a half-duplex differential-bus transceiver. It chooses which of the two bus wires carries true data and which carries the complement. When the node is listening and the received line stays low for longer than a set waiting time, the block concludes that the two wires are crossed and swaps them. One polarity bit drives both directions. On transmit it selects which line is driven inverted. On receive it selects which of two digitized comparator results reaches the receiver output.

The analog front end supplies two comparator bits, one for each wire orientation. Both comparators are fail-safe: each reads high at 0 V differential. Because of this, an open, shorted or idle terminated bus reads high whichever orientation is active. The waiting time is given in clock cycles. A nominal 200 ms, within a 150 ms to 250 ms window, is reached by sizing the parameter to the clock. Traffic on the bus must never hold the line low for 100 ms or more, so ordinary data cannot trigger a swap.

Top module: `bus_polarity_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, polarity is normal: `polarity`=0, `lineInv`=2'b10 (line 1 true, line 2 inverted) and `rxSel`=0.
- R2: With the receiver enabled (`rcvEnN`=0), `rxOut` equals `cmpNorm` when `polarity`=0 and equals `cmpRev` when `polarity`=1, in the same cycle.
- R3: With the receiver disabled (`rcvEnN`=1), `rxOut` is 1 whatever the comparators show.
- R4: Call an edge qualifying when `drvEn`=0, `rcvEnN`=0 and `rxOut`=0. Polarity toggles on exactly the WAIT_CYCLES-th consecutive qualifying rising edge of `clk`. After WAIT_CYCLES-1 such edges, polarity has not changed.
- R5: A single non-qualifying edge clears the timer to zero. This holds whether the cause is `drvEn` going high, `rcvEnN` going high or `rxOut` going high. After the break, a full WAIT_CYCLES run of qualifying edges is needed again before polarity toggles.
- R6: After a toggle the timer starts again from zero. If the low condition persists for another WAIT_CYCLES edges, polarity toggles back to normal.
- R7: One state bit sets both paths: `polarity`=1 gives `lineInv`=2'b01 (line 1 inverted) and `rxSel`=1. `polarity`=0 gives `lineInv`=2'b10 and `rxSel`=0.
- R8: Fail-safe holds in both polarities: with the receiver enabled and both comparators high, `rxOut` is 1, and no qualifying edge occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Power-on reset, active low, asynchronous |
| drvEn | input | 1 | Driver enable, active high |
| rcvEnN | input | 1 | Receiver enable, active low |
| cmpNorm | input | 1 | Fail-safe comparator result for normal wire orientation |
| cmpRev | input | 1 | Fail-safe comparator result for reversed wire orientation |
| polarity | output | 1 | 0 normal, 1 reversed |
| rxOut | output | 1 | Receiver output |
| lineInv | output | 2 | Bit i high: line i+1 driven with complement of data |
| rxSel | output | 1 | Comparator select for the receive path (1 = reversed) |

## Verification
The bench builds the block with WAIT_CYCLES set to 16. With that value, the exact flip edge, the edge one short of it, a single-cycle break in the middle of a run and a second toggle back all fall within a few dozen cycles. These cases can be checked cycle by cycle. At the default value of ten million cycles they would be out of reach.

// File: rtl/bus_polarity_pkg.sv
package bus_polarity_pkg;
  typedef struct packed {
    logic flip;
  } ctrlStrobe_t;

  localparam logic POL_NORMAL = 1'b0;
endpackage

// File: rtl/polarity_timer.sv
module polarity_timer
  import bus_polarity_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 10_000_000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        drvEn,
  input  logic        rcvEnN,
  input  logic        rxOut,
  output ctrlStrobe_t strobe
);
  localparam int unsigned CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             qualify;
  logic             expire;

  assign qualify = !drvEn && !rcvEnN && !rxOut;
  assign expire  = qualify && (cnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (!qualify || expire) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strobe      = '0;
    strobe.flip = expire;
  end
endmodule

// File: rtl/polarity_datapath.sv
module polarity_datapath
  import bus_polarity_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        rcvEnN,
  input  logic        cmpNorm,
  input  logic        cmpRev,
  output logic        polarity,
  output logic        rxOut,
  output logic [1:0]  lineInv,
  output logic        rxSel
);
  logic polReg;
  logic selected;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      polReg <= POL_NORMAL;
    end else if (strobe.flip) begin
      polReg <= ~polReg;
    end
  end

  always_comb begin
    selected = polReg ? cmpRev : cmpNorm;
    rxOut    = rcvEnN ? 1'b1 : selected;
  end

  assign polarity = polReg;
  assign rxSel    = polReg;
  assign lineInv  = {~polReg, polReg};
endmodule

// File: rtl/bus_polarity_ctrl.sv
module bus_polarity_ctrl
  import bus_polarity_pkg::*;
#(
  parameter int unsigned WAIT_CYCLES = 10_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       drvEn,
  input  logic       rcvEnN,
  input  logic       cmpNorm,
  input  logic       cmpRev,
  output logic       polarity,
  output logic       rxOut,
  output logic [1:0] lineInv,
  output logic       rxSel
);
  ctrlStrobe_t strobe;

  polarity_timer #(.WAIT_CYCLES(WAIT_CYCLES)) timer_i (
    .clk    (clk),
    .rstN   (rstN),
    .drvEn  (drvEn),
    .rcvEnN (rcvEnN),
    .rxOut  (rxOut),
    .strobe (strobe)
  );

  polarity_datapath path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rcvEnN   (rcvEnN),
    .cmpNorm  (cmpNorm),
    .cmpRev   (cmpRev),
    .polarity (polarity),
    .rxOut    (rxOut),
    .lineInv  (lineInv),
    .rxSel    (rxSel)
  );
endmodule

// File: rtl/bus_polarity_checker.sv
module bus_polarity_checker (
  input logic       clk,
  input logic       rstN,
  input logic       drvEn,
  input logic       rcvEnN,
  input logic       cmpNorm,
  input logic       cmpRev,
  input logic       polarity,
  input logic       rxOut,
  input logic [1:0] lineInv,
  input logic       rxSel
);
  logic qualify;
  assign qualify = !drvEn && !rcvEnN && !rxOut;

  p_reset_normal_r1: assert property (@(posedge clk) !rstN |-> !polarity);

  p_rx_select_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rcvEnN |-> (rxOut == (rxSel ? cmpRev : cmpNorm)));

  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    rcvEnN |-> rxOut);

  p_flip_needs_qualify_r4: assert property (@(posedge clk) disable iff (!rstN)
    (polarity != $past(polarity)) |-> $past(qualify));

  p_break_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    !qualify |=> $stable(polarity));

  p_one_state_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(lineInv) == 1) && (lineInv[0] == polarity) && (rxSel == polarity));

  p_fail_safe_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cmpNorm && cmpRev) |-> rxOut);
endmodule

bind bus_polarity_ctrl bus_polarity_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .drvEn    (drvEn),
  .rcvEnN   (rcvEnN),
  .cmpNorm  (cmpNorm),
  .cmpRev   (cmpRev),
  .polarity (polarity),
  .rxOut    (rxOut),
  .lineInv  (lineInv),
  .rxSel    (rxSel)
);

// File: tb/bus_polarity_ctrl_tb_top.sv
`timescale 1ns/1ps
module bus_polarity_ctrl_tb_top;
  localparam int unsigned WAIT = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic drvEn = 1'b0;
  logic rcvEnN = 1'b1;
  logic cmpNorm = 1'b1;
  logic cmpRev = 1'b1;
  logic polarity, rxOut, rxSel;
  logic [1:0] lineInv;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bus_polarity_ctrl #(.WAIT_CYCLES(WAIT)) dut_i (
    .clk(clk), .rstN(rstN), .drvEn(drvEn), .rcvEnN(rcvEnN),
    .cmpNorm(cmpNorm), .cmpRev(cmpRev), .polarity(polarity),
    .rxOut(rxOut), .lineInv(lineInv), .rxSel(rxSel)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; drvEn = 1'b0; rcvEnN = 1'b1; cmpNorm = 1'b1; cmpRev = 1'b1;
    edges(2);
    rstN = 1'b1;
    edges(1);
  endtask

  task automatic listenLow();
    drvEn = 1'b0; rcvEnN = 1'b0; cmpNorm = 1'b0; cmpRev = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    edges(1);
    chk("R1", "polarity in reset", polarity, 0);
    rstN = 1'b1;
    edges(1);
    chk("R1", "polarity after reset", polarity, 0);
    chk("R1", "lineInv after reset", lineInv, 2);
    chk("R1", "rxSel after reset", rxSel, 0);
  endtask

  task automatic t_rx_select();
    doReset();
    rcvEnN = 1'b0; drvEn = 1'b1;
    cmpNorm = 1'b0; cmpRev = 1'b1; #1;
    chk("R2", "rxOut normal follows cmpNorm=0", rxOut, 0);
    cmpNorm = 1'b1; cmpRev = 1'b0; #1;
    chk("R2", "rxOut normal follows cmpNorm=1", rxOut, 1);
    rcvEnN = 1'b1; cmpNorm = 1'b0; cmpRev = 1'b0; #1;
    chk("R3", "rxOut with receiver disabled", rxOut, 1);
  endtask

  task automatic t_flip_exact();
    doReset();
    listenLow();
    edges(WAIT - 1);
    chk("R4", "polarity after WAIT-1 edges", polarity, 0);
    edges(1);
    chk("R4", "polarity after WAIT edges", polarity, 1);
    chk("R7", "lineInv reversed", lineInv, 1);
    chk("R7", "rxSel reversed", rxSel, 1);
    cmpRev = 1'b1; cmpNorm = 1'b0; #1;
    chk("R2", "rxOut reversed follows cmpRev=1", rxOut, 1);
    cmpRev = 1'b0; cmpNorm = 1'b1; #1;
    chk("R2", "rxOut reversed follows cmpRev=0", rxOut, 0);
    rcvEnN = 1'b1; #1;
    chk("R3", "rxOut disabled while reversed", rxOut, 1);
  endtask

  task automatic t_toggle_back();
    doReset();
    listenLow();
    edges(WAIT);
    chk("R6", "first toggle", polarity, 1);
    edges(WAIT - 1);
    chk("R6", "no second toggle at WAIT-1", polarity, 1);
    edges(1);
    chk("R6", "toggled back to normal", polarity, 0);
    chk("R7", "lineInv normal again", lineInv, 2);
  endtask

  task automatic t_break(input int kind);
    doReset();
    listenLow();
    edges(WAIT - 1);
    case (kind)
      0: drvEn = 1'b1;
      1: rcvEnN = 1'b1;
      default: cmpNorm = 1'b1;
    endcase
    edges(1);
    chk("R5", $sformatf("no flip on break kind %0d", kind), polarity, 0);
    listenLow();
    edges(WAIT - 1);
    chk("R5", $sformatf("timer cleared kind %0d", kind), polarity, 0);
    edges(1);
    chk("R5", $sformatf("flip after full run kind %0d", kind), polarity, 1);
  endtask

  task automatic t_fail_safe();
    doReset();
    drvEn = 1'b0; rcvEnN = 1'b0; cmpNorm = 1'b1; cmpRev = 1'b1;
    edges(WAIT + 4);
    chk("R8", "rxOut idle normal", rxOut, 1);
    chk("R8", "no flip on idle bus", polarity, 0);
    listenLow();
    edges(WAIT);
    chk("R8", "reached reversed", polarity, 1);
    cmpNorm = 1'b1; cmpRev = 1'b1;
    edges(WAIT + 4);
    chk("R8", "rxOut idle reversed", rxOut, 1);
    chk("R8", "stays reversed on idle bus", polarity, 1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_rx_select();
    t_flip_exact();
    t_toggle_back();
    for (int k = 0; k < 3; k++) t_break(k);
    t_fail_safe();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule